// File: doc/BRIEF.md
# Packed/Scalar SIMD Floating-Point Multiplier

This block multiplies two 128-bit vectors of IEEE-754 values. A 2-bit mode picks how the vectors are read. They can be four single-precision lanes, two double-precision lanes, or a single scalar of either precision in the lowest lane. Each active lane computes the product of the matching lanes of the two operands and rounds it to nearest, ties to even. The result takes the place of the first operand. In the scalar modes, the bits above the scalar are copied from the first operand unchanged.

Operations enter with an input valid strobe and leave exactly two cycles later with an output valid strobe. A new operation can be issued every cycle. Each result carries a 4-bit flag vector. The flags are the OR of the exception conditions raised by the active lanes of that operation only.

Subnormal inputs are taken as zero. Results too small for the normal range are flushed to a signed zero. Any NaN operand yields the default quiet NaN.

Top module: `fpsimd_mul`

## Requirements
- R1: Mode 0 (packed single): each 32-bit lane i of the result (bits 32i+31:32i, i = 0..3) is the single-precision product of the same lanes of the two operands.
- R2: Mode 1 (packed double): each 64-bit lane i of the result (bits 64i+63:64i, i = 0..1) is the double-precision product of the same lanes of the two operands.
- R3: Mode 2 (scalar single): result bits 31:0 are the single product of bits 31:0 of the operands, and result bits 127:32 equal bits 127:32 of the first operand.
- R4: Mode 3 (scalar double): result bits 63:0 are the double product of bits 63:0 of the operands, and result bits 127:64 equal bits 127:64 of the first operand.
- R5: Finite products round to nearest, ties to even. Flag bit 0 (inexact) is set when any discarded product bit is nonzero.
- R6: A rounded exponent above the largest finite exponent gives an infinity with the product sign. It sets flag bit 2 (overflow) and bit 0.
- R7: A subnormal input counts as a zero of its sign. A rounded exponent below the smallest normal exponent gives a signed zero and sets flag bit 1 (underflow) and bit 0. Overflow and underflow are never raised together in one lane.
- R8: A NaN in either lane operand gives the default quiet NaN: 0x7FC00000 for single, 0x7FF8000000000000 for double. Infinity times zero gives the same value and sets flag bit 3 (invalid).
- R9: The flags of an operation are the OR over its active lanes only. Exceptions that would arise in the upper lanes during a scalar mode do not appear.
- R10: out_valid is low after reset and equals in_valid from two clocks earlier. Back-to-back operations in consecutive cycles each produce their own result.
- R11: The sign of every non-NaN result, including zeros and infinities, is the XOR of the operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| in_mode | input | 2 | 0 packed single, 1 packed double, 2 scalar single, 3 scalar double |
| in_a | input | 128 | First operand; unused lanes pass to the result |
| in_b | input | 128 | Second operand |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| out_res | output | 128 | Result vector |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} for the active lanes |

## Verification
The bench builds the block with its default lane formats: 8/23 exponent/fraction for single and 11/52 for double, four and two lanes. With these formats the exhaustive cross products of the special encodings (signed zeros, subnormals, infinities, quiet and signalling NaNs, extreme normals) can be swept in both scalar modes. The bench also runs long back-to-back random streams in all four modes and directed ties for the even rounding. Expected single results come from an exact double-precision product rounded by the bench. Expected double results come from the host's double multiply, with inexact derived from a wide integer product of the fractions.

// File: rtl/fpsimd_pkg.sv
package fpsimd_pkg;
    localparam int VEC_W    = 128;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
    localparam int SP_LANES = VEC_W / SP_W;
    localparam int DP_LANES = VEC_W / DP_W;

    typedef enum logic [1:0] {
        MODE_PS = 2'd0,
        MODE_PD = 2'd1,
        MODE_SS = 2'd2,
        MODE_SD = 2'd3
    } mode_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    typedef struct packed {
        logic             valid;
        mode_e            mode;
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
    } issue_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] res;
        flags_t           flags;
    } result_t;
endpackage

// File: rtl/fpsimd_lane_mul.sv
module fpsimd_lane_mul #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    output logic [EXP_W+MAN_W:0] prod,
    output fpsimd_pkg::flags_t   flags
);
    localparam int W    = EXP_W + MAN_W + 1;
    localparam int PW   = 2 * (MAN_W + 1);
    localparam int ES   = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam logic signed [ES-1:0] EMAX_S = ES'(EMAX);
    localparam logic signed [ES-1:0] ZERO_S = '0;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic                    sa, sb, sr;
    logic [EXP_W-1:0]        ea, eb;
    logic [MAN_W-1:0]        ma, mb;
    logic                    a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic [PW-1:0]           raw;
    logic [PW-2:0]           aligned;
    logic                    norm, guard, sticky, up;
    logic [MAN_W-1:0]        frac;
    logic [MAN_W:0]          frac_r;
    logic signed [ES-1:0]    exp_s, exp_r;

    always_comb begin
        {sa, ea, ma} = op_a;
        {sb, eb, mb} = op_b;
        sr     = sa ^ sb;
        a_nan  = (ea == EXP_W'(EMAX)) && (ma != '0);
        b_nan  = (eb == EXP_W'(EMAX)) && (mb != '0);
        a_inf  = (ea == EXP_W'(EMAX)) && (ma == '0);
        b_inf  = (eb == EXP_W'(EMAX)) && (mb == '0);
        a_zero = (ea == '0);
        b_zero = (eb == '0);

        // significand product in [1,4); realign so the leading one is dropped
        raw     = PW'({1'b1, ma}) * PW'({1'b1, mb});
        norm    = raw[PW-1];
        aligned = norm ? raw[PW-2:0] : {raw[PW-3:0], 1'b0};
        frac    = aligned[PW-2 -: MAN_W];
        guard   = aligned[MAN_W];
        sticky  = |aligned[MAN_W-1:0];
        up      = guard & (sticky | frac[0]);
        frac_r  = {1'b0, frac} + (MAN_W+1)'(up);
        exp_s   = ES'(ea) + ES'(eb) - ES'(BIAS) + ES'(norm);
        exp_r   = exp_s + ES'(frac_r[MAN_W]);

        flags = '0;
        if (a_nan || b_nan) begin
            prod = QNAN;
        end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
            prod          = QNAN;
            flags.invalid = 1'b1;
        end else if (a_inf || b_inf) begin
            prod = {sr, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (a_zero || b_zero) begin
            prod = {sr, {(W-1){1'b0}}};
        end else if (exp_r >= EMAX_S) begin
            prod           = {sr, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            flags.overflow = 1'b1;
            flags.inexact  = 1'b1;
        end else if (exp_r <= ZERO_S) begin
            prod            = {sr, {(W-1){1'b0}}};
            flags.underflow = 1'b1;
            flags.inexact   = 1'b1;
        end else begin
            prod          = {sr, exp_r[EXP_W-1:0], frac_r[MAN_W-1:0]};
            flags.inexact = guard | sticky;
        end
    end

    always_comb begin
        // R7
        ovf_unf_excl_chk: assert (!(flags.overflow && flags.underflow));
    end
endmodule

// File: rtl/fpsimd_merge.sv
module fpsimd_merge
    import fpsimd_pkg::*;
(
    input  mode_e                       mode,
    input  logic [VEC_W-1:0]            op_a,
    input  logic [VEC_W-1:0]            sp_vec,
    input  flags_t [SP_LANES-1:0]       sp_flags,
    input  logic [VEC_W-1:0]            dp_vec,
    input  flags_t [DP_LANES-1:0]       dp_flags,
    output logic [VEC_W-1:0]            res,
    output flags_t                      flags
);
    flags_t sp_any, dp_any;

    always_comb begin
        sp_any = '0;
        for (int i = 0; i < SP_LANES; i++) sp_any = sp_any | sp_flags[i];
        dp_any = '0;
        for (int i = 0; i < DP_LANES; i++) dp_any = dp_any | dp_flags[i];

        unique case (mode)
            MODE_PS: begin
                res   = sp_vec;
                flags = sp_any;
            end
            MODE_PD: begin
                res   = dp_vec;
                flags = dp_any;
            end
            MODE_SS: begin
                res   = {op_a[VEC_W-1:SP_W], sp_vec[SP_W-1:0]};
                flags = sp_flags[0];
            end
            default: begin
                res   = {op_a[VEC_W-1:DP_W], dp_vec[DP_W-1:0]};
                flags = dp_flags[0];
            end
        endcase
    end
endmodule

// File: rtl/fpsimd_mul.sv
module fpsimd_mul
    import fpsimd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   in_mode,
    input  logic [127:0] in_a,
    input  logic [127:0] in_b,
    output logic         out_valid,
    output logic [127:0] out_res,
    output logic [3:0]   out_flags
);
    issue_t  s1_d, s1_q;
    result_t s2_d, s2_q;

    logic   [SP_LANES-1:0][SP_W-1:0] sp_res;
    flags_t [SP_LANES-1:0]           sp_flags;
    logic   [DP_LANES-1:0][DP_W-1:0] dp_res;
    flags_t [DP_LANES-1:0]           dp_flags;
    logic   [VEC_W-1:0]              merged_res;
    flags_t                          merged_flags;

    for (genvar i = 0; i < SP_LANES; i++) begin : g_sp
        fpsimd_lane_mul #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_lane (
            .op_a  (s1_q.a[i*SP_W +: SP_W]),
            .op_b  (s1_q.b[i*SP_W +: SP_W]),
            .prod  (sp_res[i]),
            .flags (sp_flags[i])
        );
    end

    for (genvar i = 0; i < DP_LANES; i++) begin : g_dp
        fpsimd_lane_mul #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_lane (
            .op_a  (s1_q.a[i*DP_W +: DP_W]),
            .op_b  (s1_q.b[i*DP_W +: DP_W]),
            .prod  (dp_res[i]),
            .flags (dp_flags[i])
        );
    end

    fpsimd_merge u_merge (
        .mode     (s1_q.mode),
        .op_a     (s1_q.a),
        .sp_vec   (sp_res),
        .sp_flags (sp_flags),
        .dp_vec   (dp_res),
        .dp_flags (dp_flags),
        .res      (merged_res),
        .flags    (merged_flags)
    );

    always_comb begin
        s1_d.valid = in_valid;
        s1_d.mode  = mode_e'(in_mode);
        s1_d.a     = in_a;
        s1_d.b     = in_b;
        s2_d.valid = s1_q.valid;
        s2_d.res   = merged_res;
        s2_d.flags = merged_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_res   = s2_q.res;
    assign out_flags = s2_q.flags;

    // edges seen since reset, saturating at two, so $past(...,2) stays in range
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R3
    ss_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid && $past(in_mode, 2) == 2'd2)
        |-> (out_res[127:32] == $past(in_a[127:32], 2)));

    // R4
    sd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid && $past(in_mode, 2) == 2'd3)
        |-> (out_res[127:64] == $past(in_a[127:64], 2)));

    // R6
    ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_flags[2] || out_flags[1])) |-> out_flags[0]);
endmodule

// File: tb/fpsimd_mul_test.sv
`timescale 1ns/1ps
module fpsimd_mul_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = 2'd0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_res;
    logic [3:0]   out_flags;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    logic [31:0] seed = 32'h1234_5677;

    logic         p_valid = 1'b0;
    logic [127:0] p_res   = '0;
    logic [3:0]   p_flags = '0;
    string        p_tag   = "";

    always #4 clk = ~clk;

    fpsimd_mul uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res),
        .out_flags(out_flags)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] gen_sp();
        logic [31:0] r = rnd();
        logic [7:0]  e = 8'(87 + (rnd() % 81));
        return {r[31], e, r[22:0]};
    endfunction

    function automatic logic [63:0] gen_dp();
        logic [31:0] r1 = rnd();
        logic [31:0] r2 = rnd();
        logic [10:0] e = 11'(823 + (rnd() % 401));
        return {r1[31], e, r1[19:0], r2};
    endfunction

    // single product: exact in double, then rounded to single here
    function automatic void ref_sp(input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] r, output logic [3:0] f);
        logic sr = a[31] ^ b[31];
        logic a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        logic b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        logic a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        logic b_inf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        logic a_z = (a[30:23] == 0);
        logic b_z = (b[30:23] == 0);
        real ra, rb;
        logic [63:0] pb;
        logic [23:0] m;
        logic g, st, up;
        int e;
        f = 4'b0000;
        if (a_nan || b_nan) r = 32'h7FC0_0000;
        else if ((a_inf && b_z) || (b_inf && a_z)) begin
            r = 32'h7FC0_0000; f = 4'b1000;
        end else if (a_inf || b_inf) r = {sr, 8'hFF, 23'd0};
        else if (a_z || b_z) r = {sr, 31'd0};
        else begin
            ra = $bitstoreal({a[31], 11'(int'(a[30:23]) - 127 + 1023), a[22:0], 29'd0});
            rb = $bitstoreal({b[31], 11'(int'(b[30:23]) - 127 + 1023), b[22:0], 29'd0});
            pb = $realtobits(ra * rb);
            e  = int'(pb[62:52]) - 1023 + 127;
            g  = pb[28];
            st = |pb[27:0];
            up = g & (st | pb[29]);
            m  = {1'b0, pb[51:29]} + 24'(up);
            if (m[23]) e = e + 1;
            if (e >= 255) begin
                r = {sr, 8'hFF, 23'd0}; f = 4'b0101;
            end else if (e <= 0) begin
                r = {sr, 31'd0}; f = 4'b0011;
            end else begin
                r = {sr, 8'(e), m[22:0]}; f = {3'b000, g | st};
            end
        end
    endfunction

    // double product: host double multiply, inexact from the wide fraction product
    function automatic void ref_dp(input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] r, output logic [3:0] f);
        logic sr = a[63] ^ b[63];
        logic a_nan = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
        logic b_nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        logic a_inf = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
        logic b_inf = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        logic a_z = (a[62:52] == 0);
        logic b_z = (b[62:52] == 0);
        logic [63:0]  pb;
        logic [105:0] wide;
        logic inx;
        f = 4'b0000;
        if (a_nan || b_nan) r = 64'h7FF8_0000_0000_0000;
        else if ((a_inf && b_z) || (b_inf && a_z)) begin
            r = 64'h7FF8_0000_0000_0000; f = 4'b1000;
        end else if (a_inf || b_inf) r = {sr, 11'h7FF, 52'd0};
        else if (a_z || b_z) r = {sr, 63'd0};
        else begin
            pb   = $realtobits($bitstoreal(a) * $bitstoreal(b));
            wide = {53'd1, a[51:0]} * {53'd1, b[51:0]};
            inx  = wide[105] ? |wide[52:0] : |wide[51:0];
            if (pb[62:52] == 11'h7FF) begin
                r = {sr, 11'h7FF, 52'd0}; f = 4'b0101;
            end else if (pb[62:52] == 0) begin
                r = {sr, 63'd0}; f = 4'b0011;
            end else begin
                r = pb; f = {3'b000, inx};
            end
        end
    endfunction

    function automatic void ref_vec(input logic [1:0] m, input logic [127:0] a,
                                    input logic [127:0] b, output logic [127:0] r,
                                    output logic [3:0] f);
        logic [31:0] rs; logic [63:0] rd; logic [3:0] fl;
        r = a; f = 4'b0000;
        case (m)
            2'd0: for (int i = 0; i < 4; i++) begin
                ref_sp(a[i*32 +: 32], b[i*32 +: 32], rs, fl);
                r[i*32 +: 32] = rs; f = f | fl;
            end
            2'd1: for (int i = 0; i < 2; i++) begin
                ref_dp(a[i*64 +: 64], b[i*64 +: 64], rd, fl);
                r[i*64 +: 64] = rd; f = f | fl;
            end
            2'd2: begin ref_sp(a[31:0], b[31:0], rs, fl); r[31:0] = rs; f = fl; end
            default: begin ref_dp(a[63:0], b[63:0], rd, fl); r[63:0] = rd; f = fl; end
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one slot; on return the output of the previous slot is compared
    task automatic step(input logic v, input logic [1:0] m, input logic [127:0] a,
                        input logic [127:0] b, input string tag);
        logic [127:0] er; logic [3:0] ef;
        ref_vec(m, a, b, er, ef);
        in_valid = v; in_mode = m; in_a = a; in_b = b;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == p_valid, "R10 out_valid", 128'(out_valid), 128'(p_valid));
        if (p_valid) begin
            chk(out_res == p_res, {p_tag, " result"}, out_res, p_res);
            chk(out_flags == p_flags, {p_tag, " flags"}, 128'(out_flags), 128'(p_flags));
        end
        p_valid = v; p_res = er; p_flags = ef; p_tag = tag;
    endtask

    function automatic logic [127:0] rnd128();
        return {rnd(), rnd(), rnd(), rnd()};
    endfunction

    logic [31:0] sp_sp [14] = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
                                32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'h7F80_0001,
                                32'h3F80_0000, 32'hBFC0_0000, 32'h7F7F_FFFF, 32'h0080_0000,
                                32'h4040_0000, 32'h3F80_0001};
    logic [63:0] dp_sp [12] = '{64'h0, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
                                64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
                                64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001,
                                64'h3FF0_0000_0000_0000, 64'hBFF8_0000_0000_0000,
                                64'h7FEF_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000,
                                64'h3FF0_0000_0000_0001};

    string mode_tag [4] = '{"R1 R5", "R2", "R3", "R4"};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10 reset valid", 128'(out_valid), 128'(0));
        chk(out_res == '0, "R10 reset result", out_res, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 R11 R7: all pairs of special singles, scalar single
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++)
                step(1'b1, 2'd2, {rnd(), rnd(), rnd(), sp_sp[i]},
                     {rnd(), rnd(), rnd(), sp_sp[j]}, "R3 R7 R8 R11 special-sp");

        // R8 R11 R6: all pairs of special doubles, scalar double
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                step(1'b1, 2'd3, {rnd(), rnd(), dp_sp[i]}, {rnd(), rnd(), dp_sp[j]},
                     "R4 R6 R8 R11 special-dp");

        // R5 ties: tie to even down and tie to even up
        step(1'b1, 2'd2, 128'h3F80_0800, 128'h3F80_0800, "R5 tie-down");
        step(1'b1, 2'd2, 128'h4040_0000, 128'h3F80_0001, "R5 tie-up");
        step(1'b1, 2'd3, 128'h3FF0_0000_0000_0001, 128'h3FF0_0000_0000_0001, "R5 dp round");

        // R6 R7 double range limits
        step(1'b1, 2'd3, 128'h7E70_0000_0000_0000, 128'hFE70_0000_0000_0000, "R6 dp overflow");
        step(1'b1, 2'd3, 128'h0170_0000_0000_0000, 128'h8170_0000_0000_0000, "R7 dp underflow");

        // R9: upper lanes hold inf*0 and overflow patterns, scalar modes must hide them
        step(1'b1, 2'd2, {32'h7F80_0000, 32'h7F7F_FFFF, 32'h0, 32'h3F80_0000},
             {32'h0000_0000, 32'h7F7F_FFFF, 32'h7F80_0000, 32'h3FC0_0000}, "R9 scalar-sp");
        step(1'b1, 2'd3, {64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000},
             {64'h0, 64'h4000_0000_0000_0000}, "R9 scalar-dp");
        step(1'b1, 2'd0, {32'h7F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000},
             {32'h0000_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, "R9 packed-or");

        // random streams with occasional idle slots, all modes
        for (int k = 0; k < 2400; k++) begin
            logic [1:0]   m = 2'(k % 4);
            logic [127:0] a, b;
            if (m == 2'd0 || m == 2'd2) begin
                a = {gen_sp(), gen_sp(), gen_sp(), gen_sp()};
                b = {gen_sp(), gen_sp(), gen_sp(), gen_sp()};
            end else begin
                a = {gen_dp(), gen_dp()};
                b = {gen_dp(), gen_dp()};
            end
            if (m >= 2'd2) begin
                a[127:64] = rnd128()[127:64];
            end
            step((rnd() % 7) != 0, m, a, b, mode_tag[m]);
        end

        step(1'b0, 2'd0, '0, '0, "idle");
        step(1'b0, 2'd0, '0, '0, "idle");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule